// File: doc/BRIEF.md
# Packed BCD Integer Converter

The block moves a signed integer between two forms. One is a ten-byte packed decimal operand held in a byte-addressed store. The other is a 64-bit two's-complement value. It works one byte per clock, and the byte store sits on a simple read/write port whose read data returns in the same cycle as the address.

Byte 9 of the operand carries only the sign, in bit 7. Bytes 0 through 8 each carry two decimal digits, with the high nibble the more significant digit and byte 0 the least significant byte.

A load reads the nine digit bytes from the most significant down, folding each byte into a binary accumulator. It then reads the sign byte and negates the result when bit 7 is set. A store writes the sign byte first and then the digit bytes from the least significant up, each taken from the magnitude's remainder modulo 100.

One start pulse begins a conversion, and a single-cycle done pulse ends it. Both directions flag operands that cannot be represented.

Top module: `bcd_int_conv`

## Requirements
- R1: After reset, busy, done, mem_rd, mem_wr and error are 0 and int_out is 0.
- R2: A load issues exactly ten reads, one per cycle, starting the cycle after start is accepted. The addresses are 8, 7, ..., 0 and then 9.
- R3: A load folds each digit byte b into the accumulator as acc*100 + b[7:4]*10 + b[3:0], so byte 0 holds the two least significant digits.
- R4: At the end of a load, int_out is the negated accumulator when bit 7 of byte 9 is 1, and the accumulator otherwise. Bits 6:0 of byte 9 have no effect.
- R5: A load reports error=1 with done when any nibble of bytes 0 to 8 exceeds 9, and error=0 otherwise.
- R6: A store issues exactly ten writes, one per cycle. The first goes to address 9 with data 0x80 for a negative input and 0x00 otherwise, and addresses 0 to 8 follow in ascending order.
- R7: Store digit byte k holds (tens<<4)|units of (|x| / 100^k) mod 100, so every byte after the magnitude runs out is 0x00.
- R8: A store reports error=1 with done when |x| exceeds 10^18-1, including x = -2^63, and error=0 otherwise.
- R9: busy is 1 from the cycle after an accepted start through the last transfer. done is 1 for exactly the one cycle after the last transfer.
- R10: A start pulse while busy is ignored: the running conversion keeps its direction, addresses and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a conversion when idle |
| to_bcd | input | 1 | Direction, sampled with start: 1 = store integer as decimal, 0 = load |
| int_in | input | 64 | Signed integer to store |
| int_out | output | 64 | Signed integer produced by the last load |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Invalid digit (load) or magnitude too large (store), valid with done |
| mem_addr | output | 4 | Byte index 0 to 9 |
| mem_rd | output | 1 | Read strobe; mem_rdata is taken in the same cycle |
| mem_rdata | input | 8 | Read data |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |

## Verification
The bench drives a pure-zero load, the largest 18-digit value, and a sign byte whose low bits are all set. A design that tested the whole sign byte instead of bit 7 would then return a negative number, and one that reversed the nibble weights would scramble every digit. It stores -1, -2^63, 10^18-1 and 10^18. These expose a magnitude taken without the two's-complement negate, a range limit off by one, and a missing range check on the most negative value. It also injects a nibble of 0xA deep in a load and pulses start mid-load with the opposite direction: a design that re-armed on that pulse would begin writing and break the expected read stream.

// File: rtl/bcd_conv_pkg.sv
package bcd_conv_pkg;

  typedef enum logic {
    DIR_LOAD  = 1'b0,
    DIR_STORE = 1'b1
  } conv_dir_e;

  // true when a BCD nibble holds a non-decimal code
  function automatic logic nibble_bad(input logic [3:0] n);
    return n > 4'd9;
  endfunction

  // packs a value below 100 into two decimal nibbles
  function automatic logic [7:0] pack_pair(input logic [6:0] v);
    logic [6:0] tens;
    logic [6:0] units;
    tens  = v / 7'd10;
    units = v % 7'd10;
    return {tens[3:0], units[3:0]};
  endfunction

endpackage

// File: rtl/bcd_step_seq.sv
module bcd_step_seq
  import bcd_conv_pkg::*;
#(
  parameter int DIGIT_BYTES = 9,
  parameter int ADDR_W      = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              store_req,
  output logic              run,
  output conv_dir_e         dir,
  output logic              accept,
  output logic              first_xfer,
  output logic              last_xfer,
  output logic [ADDR_W-1:0] addr,
  output logic              done
);
  localparam int CNT_W    = $clog2(DIGIT_BYTES + 1);
  localparam int SIGN_IDX = DIGIT_BYTES;

  logic [CNT_W-1:0] step;

  assign accept     = start && !run;
  assign first_xfer = run && (step == '0);
  assign last_xfer  = run && (step == CNT_W'(DIGIT_BYTES));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run  <= 1'b0;
      step <= '0;
      dir  <= DIR_LOAD;
      done <= 1'b0;
    end else begin
      done <= last_xfer;
      if (accept) begin
        run  <= 1'b1;
        step <= '0;
        dir  <= store_req ? DIR_STORE : DIR_LOAD;
      end else if (run) begin
        if (last_xfer) run <= 1'b0;
        step <= step + 1'b1;
      end
    end
  end

  // load walks digit bytes high to low then the sign; store does sign first
  always_comb begin
    if (dir == DIR_LOAD) begin
      if (int'(step) < DIGIT_BYTES) addr = ADDR_W'(DIGIT_BYTES - 1 - int'(step));
      else                          addr = ADDR_W'(SIGN_IDX);
    end else begin
      if (step == '0) addr = ADDR_W'(SIGN_IDX);
      else            addr = ADDR_W'(int'(step) - 1);
    end
  end

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (run && start && !last_xfer) |=> (run && dir == $past(dir)));

endmodule

// File: rtl/bcd_load_path.sv
module bcd_load_path
  import bcd_conv_pkg::*;
#(
  parameter int INT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             digit_en,
  input  logic             sign_en,
  input  logic [7:0]       rdata,
  output logic [INT_W-1:0] value,
  output logic             bad
);
  logic [INT_W-1:0] acc;

  function automatic logic [INT_W-1:0] fold(input logic [INT_W-1:0] a,
                                            input logic [7:0] b);
    return a * INT_W'(100) + INT_W'(b[7:4]) * INT_W'(10) + INT_W'(b[3:0]);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc   <= '0;
      value <= '0;
      bad   <= 1'b0;
    end else if (clear) begin
      acc <= '0;
      bad <= 1'b0;
    end else begin
      if (digit_en) begin
        acc <= fold(acc, rdata);
        bad <= bad | nibble_bad(rdata[7:4]) | nibble_bad(rdata[3:0]);
      end
      if (sign_en) value <= rdata[7] ? (~acc + 1'b1) : acc;
    end
  end

endmodule

// File: rtl/bcd_store_path.sv
module bcd_store_path
  import bcd_conv_pkg::*;
#(
  parameter int INT_W       = 64,
  parameter int DIGIT_BYTES = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [INT_W-1:0] operand,
  input  logic             digit_en,
  input  logic             sign_sel,
  output logic [7:0]       wdata,
  output logic             too_big
);
  function automatic logic [INT_W-1:0] decimal_limit(input int digits);
    logic [INT_W-1:0] p;
    p = INT_W'(1);
    for (int i = 0; i < digits; i++) p = p * INT_W'(10);
    return p - 1'b1;
  endfunction

  localparam logic [INT_W-1:0] MAX_MAG = decimal_limit(2 * DIGIT_BYTES);

  logic [INT_W-1:0] mag;
  logic [INT_W-1:0] mag_in;
  logic [INT_W-1:0] rem;
  logic             neg_q;

  assign mag_in = operand[INT_W-1] ? (~operand + 1'b1) : operand;
  assign rem    = mag % INT_W'(100);
  assign wdata  = sign_sel ? {neg_q, 7'b0} : pack_pair(rem[6:0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mag     <= '0;
      neg_q   <= 1'b0;
      too_big <= 1'b0;
    end else if (load) begin
      mag     <= mag_in;
      neg_q   <= operand[INT_W-1];
      too_big <= mag_in > MAX_MAG;
    end else if (digit_en) begin
      mag <= mag / INT_W'(100);
    end
  end

  p_digit_nibbles_r7: assert property (@(posedge clk) disable iff (!rst_n)
    digit_en |-> (wdata[7:4] <= 4'd9 && wdata[3:0] <= 4'd9));

endmodule

// File: rtl/bcd_int_conv.sv
module bcd_int_conv
  import bcd_conv_pkg::*;
#(
  parameter int INT_W       = 64,
  parameter int DIGIT_BYTES = 9,
  parameter int ADDR_W      = $clog2(DIGIT_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              to_bcd,
  input  logic [INT_W-1:0]  int_in,
  output logic [INT_W-1:0]  int_out,
  output logic              busy,
  output logic              done,
  output logic              error,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  input  logic [7:0]        mem_rdata,
  output logic              mem_wr,
  output logic [7:0]        mem_wdata
);
  localparam int SIGN_IDX = DIGIT_BYTES;

  logic      run, accept, first_xfer, last_xfer;
  conv_dir_e dir;
  logic      ld_bad, st_big;

  // named events for the assertions and the datapaths
  logic ld_start, st_start, ld_digit, ld_sign, st_digit;
  assign ld_start = accept && !to_bcd;
  assign st_start = accept && to_bcd;
  assign ld_digit = mem_rd && !last_xfer;
  assign ld_sign  = mem_rd && last_xfer;
  assign st_digit = mem_wr && !first_xfer;

  bcd_step_seq #(.DIGIT_BYTES(DIGIT_BYTES), .ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .store_req(to_bcd),
    .run(run), .dir(dir), .accept(accept), .first_xfer(first_xfer),
    .last_xfer(last_xfer), .addr(mem_addr), .done(done)
  );

  bcd_load_path #(.INT_W(INT_W)) u_load (
    .clk(clk), .rst_n(rst_n), .clear(ld_start), .digit_en(ld_digit),
    .sign_en(ld_sign), .rdata(mem_rdata), .value(int_out), .bad(ld_bad)
  );

  bcd_store_path #(.INT_W(INT_W), .DIGIT_BYTES(DIGIT_BYTES)) u_store (
    .clk(clk), .rst_n(rst_n), .load(st_start), .operand(int_in),
    .digit_en(st_digit), .sign_sel(first_xfer), .wdata(mem_wdata),
    .too_big(st_big)
  );

  assign busy   = run;
  assign mem_rd = run && (dir == DIR_LOAD);
  assign mem_wr = run && (dir == DIR_STORE);
  assign error  = (dir == DIR_LOAD) ? ld_bad : st_big;

  p_one_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  p_addr_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr) |-> (mem_addr <= ADDR_W'(SIGN_IDX)));

  p_sign_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_wr) |-> (mem_addr == ADDR_W'(SIGN_IDX) &&
                       (mem_wdata == 8'h80 || mem_wdata == 8'h00)));

  p_done_after_xfer_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(mem_rd || mem_wr) && !busy);

endmodule

// File: tb/test_bcd_int_conv.sv
`timescale 1ns/1ps
module test_bcd_int_conv;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        start = 0;
  logic        to_bcd = 0;
  logic [63:0] int_in = '0;
  logic [63:0] int_out;
  logic        busy, done, error, mem_rd, mem_wr;
  logic [3:0]  mem_addr;
  logic [7:0]  mem_rdata, mem_wdata;

  logic [7:0] mem [0:9];

  int nchk = 0;
  int nerr = 0;

  logic [3:0]  rd_q[$];
  logic [11:0] wr_q[$];
  logic [63:0] val_q[$];
  logic        err_q[$];
  logic        isld_q[$];
  logic        prev_xfer = 0;
  logic        prev_done = 0;

  always #10 clk = ~clk;

  assign mem_rdata = mem[mem_addr];

  bcd_int_conv i_bcd_int_conv (
    .clk(clk), .rst_n(rst_n), .start(start), .to_bcd(to_bcd), .int_in(int_in),
    .int_out(int_out), .busy(busy), .done(done), .error(error),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_rdata(mem_rdata),
    .mem_wr(mem_wr), .mem_wdata(mem_wdata)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops the scoreboard as transfers and completions appear
  always @(negedge clk) if (rst_n) begin
    if (mem_rd) begin
      if (rd_q.size() == 0) chk(0, "R2 unexpected read", 64'(mem_addr), 64'hf);
      else begin
        logic [3:0] ea;
        ea = rd_q.pop_front();
        chk(mem_addr == ea, "R2 read address", 64'(mem_addr), 64'(ea));
      end
    end
    if (mem_wr) begin
      if (wr_q.size() == 0) chk(0, "R10 unexpected write", 64'(mem_addr), 64'hf);
      else begin
        logic [11:0] ew;
        ew = wr_q.pop_front();
        if (ew[11:8] == 4'd9)
          chk({mem_addr, mem_wdata} == ew, "R6 sign write", 64'({mem_addr, mem_wdata}), 64'(ew));
        else
          chk({mem_addr, mem_wdata} == ew, "R7 digit write", 64'({mem_addr, mem_wdata}), 64'(ew));
      end
    end
    if (done) begin
      chk(prev_xfer && !prev_done, "R9 done timing", 64'({prev_xfer, prev_done}), 64'b10);
      if (val_q.size() == 0) chk(0, "R9 unexpected done", 64'd1, 64'd0);
      else begin
        logic [63:0] ev;
        logic ee, il;
        ev = val_q.pop_front();
        ee = err_q.pop_front();
        il = isld_q.pop_front();
        if (il) begin
          chk(int_out == ev, "R3 R4 load value", int_out, ev);
          chk(error == ee, "R5 load error", 64'(error), 64'(ee));
        end else begin
          chk(error == ee, "R8 store error", 64'(error), 64'(ee));
        end
      end
    end
    prev_xfer = mem_rd || mem_wr;
    prev_done = done;
  end

  // reference: decimal digits of a magnitude, two per byte
  function automatic void to_bytes(input logic [63:0] mag, output logic [7:0] b [0:8]);
    logic [63:0] m;
    m = mag;
    for (int i = 0; i < 9; i++) begin
      logic [3:0] lo, hi;
      lo = 4'(m % 10); m = m / 10;
      hi = 4'(m % 10); m = m / 10;
      b[i] = {hi, lo};
    end
  endfunction

  task automatic pulse_start(input logic dir);
    @(negedge clk);
    to_bcd = dir;
    start  = 1;
    @(negedge clk);
    start = 0;
    chk(busy == 1'b1, "R9 busy after start", 64'(busy), 64'd1);
  endtask

  task automatic wait_idle();
    while (val_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // load the current memory image; the reference works digit by digit
  task automatic run_load(input bit poke_busy);
    logic [63:0] v;
    logic bad;
    v = '0; bad = 0;
    for (int i = 8; i >= 0; i--) begin
      v = v * 10 + 64'(mem[i][7:4]);
      v = v * 10 + 64'(mem[i][3:0]);
      if (mem[i][7:4] > 9 || mem[i][3:0] > 9) bad = 1;
      rd_q.push_back(4'(i));
    end
    rd_q.push_back(4'd9);
    if (mem[9][7]) v = -v;
    val_q.push_back(v); err_q.push_back(bad); isld_q.push_back(1);
    pulse_start(1'b0);
    if (poke_busy) begin
      repeat (2) @(negedge clk);
      to_bcd = 1; start = 1;       // R10: must be ignored
      @(negedge clk);
      start = 0; to_bcd = 0;
      chk(busy == 1'b1, "R10 still busy", 64'(busy), 64'd1);
    end
    wait_idle();
  endtask

  task automatic set_load(input logic [63:0] mag, input logic [7:0] sgn);
    logic [7:0] b [0:8];
    to_bytes(mag, b);
    for (int i = 0; i < 9; i++) mem[i] = b[i];
    mem[9] = sgn;
  endtask

  task automatic run_store(input logic [63:0] x);
    logic [63:0] mag;
    logic [7:0] b [0:8];
    mag = x[63] ? -x : x;
    to_bytes(mag, b);
    wr_q.push_back({4'd9, x[63] ? 8'h80 : 8'h00});
    for (int i = 0; i < 9; i++) wr_q.push_back({4'(i), b[i]});
    val_q.push_back('0);
    err_q.push_back(mag > 64'd999999999999999999);
    isld_q.push_back(0);
    int_in = x;
    pulse_start(1'b1);
    wait_idle();
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL R9 watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 10; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !done && !mem_rd && !mem_wr && !error && int_out == 0,
        "R1 reset state", {int_out[59:0], busy, done, mem_rd, mem_wr}, 64'd0);

    set_load(64'd0, 8'h00);                   run_load(0); // R3 zero
    set_load(64'd999999999999999999, 8'h00);  run_load(0); // R3 max
    set_load(64'd1234567890123456, 8'h80);    run_load(0); // R4 negative
    set_load(64'd42, 8'h7f);                  run_load(0); // R4 low sign bits ignored
    set_load(64'd987654321, 8'hff);           run_load(0); // R4 all sign bits set
    set_load(64'd55, 8'h00); mem[3] = 8'h1a;  run_load(0); // R5 bad nibble
    set_load(64'd55, 8'h00); mem[8] = 8'hc0;  run_load(0); // R5 bad high nibble
    set_load(64'd31415926535, 8'h80);         run_load(1); // R10 start while busy

    run_store(64'd0);                         // R7 all zero bytes
    run_store(64'd123456789012);              // R7 zero fill
    run_store(-64'd1);                        // R6 negative sign
    run_store(64'd999999999999999999);        // R8 largest legal
    run_store(64'd1000000000000000000);       // R8 one too big
    run_store(64'h8000000000000000);          // R8 most negative
    run_store(-64'd777777777777777777);       // R6 R7 negative digits

    set_load(64'd17, 8'h00); run_load(0);     // load after stores
    chk(rd_q.size() == 0 && wr_q.size() == 0, "R2 all transfers seen",
        64'(rd_q.size() + wr_q.size()), 64'd0);
    finish_run();
  end
endmodule